// File: doc/BRIEF.md
# Eight-Bit Waveform Timer

This block is an 8-bit timer with one output-compare channel. A counter advances on each cycle in which the count-enable tick is high. Its active compare register is compared against the count. A waveform bit is set, cleared or toggled on compare events and on the counter's top value. A 2-bit mode field selects free-running count, clear-on-compare count, single-slope PWM or dual-slope (phase-correct) PWM. The modes differ in their top value, in when a compare write reaches the active register, and in the count value that raises the overflow flag.

Software reaches the block through simple write ports. One port writes the configuration (mode, output action field, pin direction bit). Other ports write the counter and the compare value, and a write-one-to-clear port clears the two sticky flags. The counter value is readable so that its progress can be observed.

Top module: `wave_timer8`

## Requirements
- R1: After a synchronous reset, the counter, the waveform bit, both flags, the pin override and the output enable are all 0. The configuration and compare registers are also 0.
- R2: In mode 00 (free-running), each tick adds one to the counter, and 0xFF wraps to 0x00. The overflow flag sets when a tick occurs while the counter is 0xFF.
- R3: In mode 10 (clear-on-compare), a tick while the counter equals the active compare value loads 0x00; otherwise the counter adds one. A compare value below the counter lets it run through 0xFF and wrap. The overflow flag sets on a tick at 0xFF.
- R4: In mode 11 (single-slope PWM), the counter counts up and wraps at 0xFF. The overflow flag sets on a tick at 0xFF.
- R5: In mode 01 (dual-slope PWM), the counter counts up from 0x00 to 0xFF, turns and counts down to 0x00, then turns up again. The overflow flag sets on a tick while the counter is 0x00.
- R6: In modes 00 and 10, a compare write reaches the active compare register at once. In modes 01 and 11, the write goes to a shadow register. The shadow is copied into the active register on a tick while the counter is 0xFF.
- R7: In modes 00 and 10, a compare match has these effects on the waveform bit: output field 01 toggles it, 10 clears it, 11 sets it, and 00 leaves it unchanged.
- R8: In mode 11, with field 10 a match clears the waveform bit and a tick at 0xFF without a match sets it. Field 11 does the reverse. The match wins when both occur together. Fields 00 and 01 leave the bit unchanged.
- R9: In mode 01, with field 10 a match while counting up clears the bit, and a match while counting down sets it. Field 11 does the reverse. Fields 00 and 01 leave the bit unchanged. The cycle at 0xFF counts as up and the cycle at 0x00 after a descent counts as down.
- R10: A compare match sets the compare flag (clear bit 0) and an overflow event sets the overflow flag (clear bit 1). Each flag stays set until a one is written to its clear bit. A set event in the same cycle wins over the clear.
- R11: A counter write overrides the tick in that cycle. In the following cycle a match neither sets the flag nor changes the waveform, although in mode 10 the counter still clears.
- R12: The pin override is high when the output field is nonzero, except for field 01 in modes 01 and 11. The output enable is the override ANDed with the direction bit. Both follow the configuration register.
- R13: In a cycle with the tick low and no counter write, the counter, direction, waveform bit and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one count per high cycle |
| cfg_we | input | 1 | Write strobe for mode, output field and direction bit |
| cfg_mode | input | 2 | Counting mode (00 free, 01 dual-slope PWM, 10 clear-on-compare, 11 single-slope PWM) |
| cfg_com | input | 2 | Waveform action field |
| cfg_pin_dir | input | 1 | Direction bit that gates the output driver |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | 8 | Compare write value |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 compare flag, bit 1 overflow flag |
| cnt_o | output | 8 | Current counter value |
| wave_o | output | 1 | Waveform bit |
| wave_ovr | output | 1 | Waveform takes over the pin |
| wave_oe | output | 1 | Pin driver enable |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest cases to reach from the ports are those where events coincide. One is a compare match in the cycle right after a counter write, which must be suppressed. Another is a shadowed compare write that lands mid-period and takes effect only at the next 0xFF. The bench sweeps every mode, every output field and compare values at 0x00, 0x01, 0x7F, 0xFE and 0xFF, with an irregular tick pattern. In each run it rewrites the compare value mid-count and writes the counter to exactly the active compare value. This forces the suppressed-match case in every mode and, with a compare of 0xFF, the match-versus-top collision.

// File: rtl/wave_timer8_pkg.sv
package wave_timer8_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_DUAL = 2'b01,
    MODE_CLR  = 2'b10,
    MODE_FAST = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_ALT  = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } tmr_act_e;

  function automatic logic mode_is_pwm(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/wave_timer8_count.sv
module wave_timer8_count
  import wave_timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic [W-1:0] ocr,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         step,
  output logic         match,
  output logic         at_max,
  output logic         ovf_ev
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic         blk;
  logic         hit;
  logic [W-1:0] nxt;
  logic         nxt_dn;

  assign step   = tick & ~cnt_we;
  assign hit    = (cnt == ocr);
  assign match  = step & hit & ~blk;
  assign at_max = (cnt == MAXV);
  assign ovf_ev = step & ((tmr_mode_e'(mode) == MODE_DUAL) ? (cnt == ZERO) : at_max);

  always_comb begin
    nxt    = cnt + ONE;
    nxt_dn = down;
    case (tmr_mode_e'(mode))
      MODE_CLR: begin
        if (hit) nxt = ZERO;
      end
      MODE_DUAL: begin
        if (down) begin
          if (cnt == ZERO) begin
            nxt    = ONE;
            nxt_dn = 1'b0;
          end else begin
            nxt = cnt - ONE;
          end
        end else if (at_max) begin
          nxt    = MAXV - ONE;
          nxt_dn = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= ZERO;
      down <= 1'b0;
      blk  <= 1'b0;
    end else begin
      blk <= cnt_we;
      if (cnt_we) begin
        cnt <= cnt_wdata;
      end else if (step) begin
        cnt  <= nxt;
        down <= nxt_dn;
      end
    end
  end

  assert_free_step_R2: assert property (@(posedge clk) disable iff (rst)
    step && tmr_mode_e'(mode) == MODE_FREE |=> cnt == W'($past(cnt) + 1'b1));
  assert_clr_zero_R3: assert property (@(posedge clk) disable iff (rst)
    step && tmr_mode_e'(mode) == MODE_CLR && cnt == ocr |=> cnt == ZERO);
  assert_dual_down_R5: assert property (@(posedge clk) disable iff (rst)
    step && tmr_mode_e'(mode) == MODE_DUAL && down && cnt != ZERO |=> cnt == W'($past(cnt) - 1'b1));
  assert_no_match_after_wr_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> !match);
  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !tick && !cnt_we |=> $stable(cnt) && $stable(down));
endmodule

// File: rtl/wave_timer8_ocr.sv
module wave_timer8_ocr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwm,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         load,
  output logic [W-1:0] act
);
  logic [W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      act    <= '0;
    end else begin
      if (cmp_we) begin
        shadow <= cmp_wdata;
        if (!pwm) act <= cmp_wdata;
      end
      if (load) act <= shadow;
    end
  end

  assert_direct_write_R6: assert property (@(posedge clk) disable iff (rst)
    cmp_we && !pwm |=> act == $past(cmp_wdata));
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
    pwm && !load |=> $stable(act));
endmodule

// File: rtl/wave_timer8_wave.sv
module wave_timer8_wave
  import wave_timer8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic [1:0] act_sel,
  input  logic       match,
  input  logic       top_ev,
  input  logic       down,
  output logic       wave
);
  logic nxt;

  always_comb begin
    nxt = wave;
    case (tmr_mode_e'(mode))
      MODE_FAST: begin
        if (match) begin
          if (tmr_act_e'(act_sel) == ACT_LOW)  nxt = 1'b0;
          if (tmr_act_e'(act_sel) == ACT_HIGH) nxt = 1'b1;
        end else if (top_ev) begin
          if (tmr_act_e'(act_sel) == ACT_LOW)  nxt = 1'b1;
          if (tmr_act_e'(act_sel) == ACT_HIGH) nxt = 1'b0;
        end
      end
      MODE_DUAL: begin
        if (match) begin
          if (tmr_act_e'(act_sel) == ACT_LOW)  nxt = down;
          if (tmr_act_e'(act_sel) == ACT_HIGH) nxt = ~down;
        end
      end
      default: begin
        if (match) begin
          case (tmr_act_e'(act_sel))
            ACT_ALT:  nxt = ~wave;
            ACT_LOW:  nxt = 1'b0;
            ACT_HIGH: nxt = 1'b1;
            default:  nxt = wave;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) wave <= 1'b0;
    else     wave <= nxt;
  end

  assert_nonpwm_set_R7: assert property (@(posedge clk) disable iff (rst)
    match && !mode[0] && act_sel == 2'b11 |=> wave);
  assert_fast_match_low_R8: assert property (@(posedge clk) disable iff (rst)
    match && mode == 2'b11 && act_sel == 2'b10 |=> !wave);
  assert_dual_down_set_R9: assert property (@(posedge clk) disable iff (rst)
    match && mode == 2'b01 && act_sel == 2'b10 && down |=> wave);
endmodule

// File: rtl/wave_timer8.sv
module wave_timer8
  import wave_timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_mode,
  input  logic [1:0]   cfg_com,
  input  logic         cfg_pin_dir,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic [1:0]   flag_clr,
  output logic [W-1:0] cnt_o,
  output logic         wave_o,
  output logic         wave_ovr,
  output logic         wave_oe,
  output logic         cmp_flag,
  output logic         ovf_flag
);
  logic [1:0]   mode_q;
  logic [1:0]   com_q;
  logic [W-1:0] ocr_act;
  logic         down;
  logic         step;
  logic         match;
  logic         at_max;
  logic         ovf_ev;
  logic         ovr_nxt;

  assign ovr_nxt = (cfg_com != 2'b00) && !(mode_is_pwm(cfg_mode) && cfg_com == 2'b01);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 2'b00;
      com_q    <= 2'b00;
      wave_ovr <= 1'b0;
      wave_oe  <= 1'b0;
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (cfg_we) begin
        mode_q   <= cfg_mode;
        com_q    <= cfg_com;
        wave_ovr <= ovr_nxt;
        wave_oe  <= ovr_nxt & cfg_pin_dir;
      end
      cmp_flag <= (cmp_flag & ~flag_clr[0]) | match;
      ovf_flag <= (ovf_flag & ~flag_clr[1]) | ovf_ev;
    end
  end

  wave_timer8_count #(.W(W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_q),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ocr(ocr_act),
    .cnt(cnt_o), .down(down), .step(step), .match(match),
    .at_max(at_max), .ovf_ev(ovf_ev)
  );

  wave_timer8_ocr #(.W(W)) u_ocr (
    .clk(clk), .rst(rst), .pwm(mode_is_pwm(mode_q)),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .load(step & at_max & mode_is_pwm(mode_q)), .act(ocr_act)
  );

  wave_timer8_wave u_wave (
    .clk(clk), .rst(rst), .mode(mode_q), .act_sel(com_q),
    .match(match), .top_ev(step & at_max), .down(down), .wave(wave_o)
  );

  assert_oe_needs_ovr_R12: assert property (@(posedge clk) disable iff (rst)
    wave_oe |-> wave_ovr);
  assert_cmp_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
    match |=> cmp_flag);
  assert_ovf_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> ovf_flag);
  assert_flags_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !tick && flag_clr == 2'b00 |=> $stable(cmp_flag) && $stable(ovf_flag));
endmodule

// File: tb/wave_timer8_tb.sv
module wave_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, cfg_we = 1'b0, cfg_pin_dir = 1'b0;
  logic [1:0] cfg_mode = 2'b00, cfg_com = 2'b00, flag_clr = 2'b00;
  logic       cnt_we = 1'b0, cmp_we = 1'b0;
  logic [7:0] cnt_wdata = 8'h00, cmp_wdata = 8'h00;
  logic [7:0] cnt_o;
  logic       wave_o, wave_ovr, wave_oe, cmp_flag, ovf_flag;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic [7:0] e_cnt, e_sh, e_act;
  logic [1:0] e_mode, e_com;
  logic       e_dn, e_blk, e_wave, e_cf, e_of, e_ovr, e_oe;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  wave_timer8 dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_com(cfg_com), .cfg_pin_dir(cfg_pin_dir), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .flag_clr(flag_clr), .cnt_o(cnt_o), .wave_o(wave_o), .wave_ovr(wave_ovr),
    .wave_oe(wave_oe), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    e_cnt = 0; e_sh = 0; e_act = 0; e_mode = 0; e_com = 0; e_dn = 0;
    e_blk = 0; e_wave = 0; e_cf = 0; e_of = 0; e_ovr = 0; e_oe = 0;
  endtask

  // next state from current model and the inputs now driven
  task automatic model_step();
    logic step, hit, match, ovf, top;
    logic [7:0] n_cnt; logic n_dn, n_wave, n_ovr;
    step  = tick && !cnt_we;
    hit   = (e_cnt == e_act);
    match = step && hit && !e_blk;
    top   = step && e_cnt == 8'hFF;
    ovf   = step && ((e_mode == 2'b01) ? e_cnt == 8'h00 : e_cnt == 8'hFF);
    n_cnt = e_cnt; n_dn = e_dn; n_wave = e_wave;
    if (cnt_we) n_cnt = cnt_wdata;
    else if (step) begin
      case (e_mode)
        2'b10: n_cnt = hit ? 8'h00 : 8'(e_cnt + 1);
        2'b01: begin
          if (!e_dn) begin
            if (e_cnt == 8'hFF) begin n_cnt = 8'hFE; n_dn = 1; end
            else n_cnt = 8'(e_cnt + 1);
          end else begin
            if (e_cnt == 8'h00) begin n_cnt = 8'h01; n_dn = 0; end
            else n_cnt = 8'(e_cnt - 1);
          end
        end
        default: n_cnt = 8'(e_cnt + 1);
      endcase
    end
    if (e_mode == 2'b11) begin
      if (match) begin
        if (e_com == 2'b10) n_wave = 0;
        if (e_com == 2'b11) n_wave = 1;
      end else if (top) begin
        if (e_com == 2'b10) n_wave = 1;
        if (e_com == 2'b11) n_wave = 0;
      end
    end else if (e_mode == 2'b01) begin
      if (match && e_com == 2'b10) n_wave = e_dn;
      if (match && e_com == 2'b11) n_wave = !e_dn;
    end else if (match) begin
      if (e_com == 2'b01) n_wave = !e_wave;
      if (e_com == 2'b10) n_wave = 0;
      if (e_com == 2'b11) n_wave = 1;
    end
    e_cf = (e_cf && !flag_clr[0]) || match;
    e_of = (e_of && !flag_clr[1]) || ovf;
    if (top && e_mode[0]) e_act = e_sh;
    if (cmp_we) begin
      e_sh = cmp_wdata;
      if (!e_mode[0]) e_act = cmp_wdata;
    end
    if (cfg_we) begin
      n_ovr = (cfg_com != 0) && !(cfg_mode[0] && cfg_com == 2'b01);
      e_mode = cfg_mode; e_com = cfg_com; e_ovr = n_ovr; e_oe = n_ovr && cfg_pin_dir;
    end
    e_blk = cnt_we; e_cnt = n_cnt; e_dn = n_dn; e_wave = n_wave;
  endtask

  task automatic compare_all();
    string cr;
    case (e_mode)
      2'b00: cr = "R2/R6/R11/R13 counter";
      2'b01: cr = "R5/R6/R11/R13 counter";
      2'b10: cr = "R3/R6/R11/R13 counter";
      default: cr = "R4/R6/R11/R13 counter";
    endcase
    chk(cr, cnt_o, e_cnt);
    case (e_mode)
      2'b01: chk("R9/R11 wave", wave_o, e_wave);
      2'b11: chk("R8/R11 wave", wave_o, e_wave);
      default: chk("R7/R11 wave", wave_o, e_wave);
    endcase
    chk("R10 cmp_flag", cmp_flag, e_cf);
    chk("R10 ovf_flag", ovf_flag, e_of);
    chk("R12 override", wave_ovr, e_ovr);
    chk("R12 enable", wave_oe, e_oe);
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk);
    compare_all();
    tick = 0; cfg_we = 0; cnt_we = 0; cmp_we = 0; flag_clr = 0;
  endtask

  task automatic do_reset();
    rst = 1; tick = 0; cfg_we = 0; cnt_we = 0; cmp_we = 0; flag_clr = 0;
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    automatic logic [7:0] ocrs[5] = '{8'h00, 8'h01, 8'h7F, 8'hFE, 8'hFF};
    @(negedge clk);
    do_reset();
    // R1: reset state
    chk("R1 counter", cnt_o, 0);
    chk("R1 wave", wave_o, 0);
    chk("R1 cmp_flag", cmp_flag, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 override", wave_ovr, 0);
    chk("R1 enable", wave_oe, 0);
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        for (int o = 0; o < 5; o++) begin
          do_reset();
          cfg_we = 1; cfg_mode = 2'(m); cfg_com = 2'(c); cfg_pin_dir = (o != 1);
          cycle();
          cmp_we = 1; cmp_wdata = ocrs[o];
          cycle();
          for (int k = 0; k < 560; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick = (lfsr[2:0] != 3'b000);
            if (k == 300) begin cmp_we = 1; cmp_wdata = ocrs[o] ^ 8'h5A; end
            if (k == 420) begin cnt_we = 1; cnt_wdata = e_act; end
            if (k % 97 == 0) flag_clr = 2'b11;
            else if (k % 53 == 0) flag_clr = 2'b01;
            cycle();
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule